// File: doc/BRIEF.md
# Bus Initiator with Termination Handling

This block is the initiator half of a parallel, multiplexed bus whose control lines are active low. An internal requester hands it read transactions over a valid/ready stream: a single word, or a burst of up to one cache line. The block asks an external arbiter for the bus and waits for the grant and an idle bus. It then runs an address phase and one data phase per word. Each target response is sorted into one of four outcomes: normal completion, disconnect, retry or abort. Every transaction ends with a single completion record. Read words leave on a result stream in the order the bus delivered them.

Burst addresses wrap inside the cache line, starting from the requested word. A target that supports bursts therefore has to disconnect at the line end. When a transaction is retried, it is parked and the bus request is withdrawn for a back-off window. A fresh internal request may go ahead of it during that window. A retried line refill is reissued only if the requester still needs the line; otherwise it is abandoned. A separate combinational output reports when a snoop is finished, so that a target serving another master's DMA cycle knows when it may accept data.

Back-pressure rules: `req_valid` must hold with stable fields until a rising edge on which `req_ready` is high. The read result stream has no ready. The block keeps its ready line asserted on every data phase, so the consumer must take each `rd_valid` beat.

Top module: `bmt_master`

## Requirements
- R1: `req_n` is low only while a transaction waits for the bus. The address phase starts only after an edge on which `gnt_n` was low and the bus frame line `snp_frame_n` was high.
- R2: In the address phase `frame_n` is low, `irdy_n` is high, `ad_oe` is high and `ad_o` carries the request address. `cbe_n` carries the command 4'h6 for an ordinary read and 4'hE for a line refill.
- R3: `irdy_n` is low throughout the data phases. `frame_n` is high on the final data phase of a burst and low on every earlier data phase. The cycle after the final transfer or a termination, both lines are high.
- R4: Beat k of a transaction with start word offset s reads address {line, (s+k) mod LINE_WORDS, 2'b00}. Each beat appears as an `rd_valid` pulse with `rd_addr` and the `rd_data` sampled from `ad_i`.
- R5: When `stop_n` and `trdy_n` are both low, the current word transfers and the transaction ends. It completes with status 1 (disconnect) if words remained, or status 0 (done) if that was the final word. `done_beats` gives the words moved.
- R6: A retry (`stop_n` low, `devsel_n` low, `trdy_n` high) moves no data. It releases the bus, and the transaction is later reissued from its first word.
- R7: A new request presented while a retried transaction is in back-off is issued on the bus before the retried one.
- R8: A retried line refill whose `refill_needed` input is low when it comes up for reissue is dropped with no further address phase. It completes with status 3 and zero beats.
- R9: A target abort (`stop_n` low, `devsel_n` and `trdy_n` high) ends the transaction with status 2 and a one-cycle `bus_err` pulse alongside `done_valid`.
- R10: If `devsel_n` stays high for MA_LIMIT data-phase edges, the transaction ends with status 2 and `bus_err`. The abort fires on the edge that completes that count.
- R11: `snoop_done` equals `snp_frame_n | snp_cbe0_n`, combinationally, at all times.
- R12: On the cycle after any edge in a data phase where `stop_n` was low, `frame_n` and `irdy_n` are both high.
- R13: After reset, `req_n`, `frame_n` and `irdy_n` are high, `req_ready` is high, and `ad_oe`, `rd_valid`, `done_valid` and `bus_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Internal request valid |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_addr | input | AW | Byte address of first word (word aligned) |
| req_len | input | BW | Words to read, 1 to LINE_WORDS |
| req_refill | input | 1 | Request is a cache-line refill |
| refill_needed | input | 1 | Requester still wants a retried refill |
| rd_valid | output | 1 | Read beat valid (no back-pressure) |
| rd_addr | output | AW | Address of the read beat |
| rd_data | output | DW | Data of the read beat |
| done_valid | output | 1 | Completion record valid, one cycle |
| done_status | output | 2 | 0 done, 1 disconnect, 2 error, 3 dropped |
| done_beats | output | BW | Words transferred |
| bus_err | output | 1 | Bus error pulse toward internal side |
| req_n | output | 1 | Bus request to arbiter, active low |
| gnt_n | input | 1 | Bus grant from arbiter, active low |
| frame_n | output | 1 | Frame, active low |
| irdy_n | output | 1 | Initiator ready, active low |
| ad_oe | output | 1 | Address drive enable |
| ad_o | output | AW | Address driven in address phase |
| ad_i | input | DW | Data returned by target |
| cbe_n | output | 4 | Command in address phase, byte enables (all on) in data phase |
| trdy_n | input | 1 | Target ready, active low |
| devsel_n | input | 1 | Device select, active low |
| stop_n | input | 1 | Target stop, active low |
| snp_frame_n | input | 1 | Observed bus frame line |
| snp_cbe0_n | input | 1 | Observed byte-lane-0 command/enable line |
| snoop_done | output | 1 | Snoop finished; a DMA target may assert ready |

## Verification
The hardest state to reach from the ports is a retried transaction sitting parked in back-off while the slot is free. Only in that state can a fresh request overtake the retried one, or a retried refill be dropped. The bench's target responder issues a retry on demand. The bench watches for the retry being driven and presents a second request at once, so that it arrives inside the back-off window. A refill-drop vector holds `refill_needed` low so that the reissue decision is taken against it.

// File: rtl/bmt_pkg.sv
package bmt_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_ADDR,
    S_DATA,
    S_TURN
  } bus_state_e;

  typedef enum logic [2:0] {
    TM_WAIT,
    TM_XFER,
    TM_DISC,
    TM_RETRY,
    TM_ABORT
  } term_e;

  typedef enum logic [1:0] {
    DS_OK   = 2'd0,
    DS_DISC = 2'd1,
    DS_ERR  = 2'd2,
    DS_DROP = 2'd3
  } done_e;

  localparam logic [3:0] CMD_READ = 4'h6;
  localparam logic [3:0] CMD_LINE = 4'hE;

endpackage

// File: rtl/bmt_term_decode.sv
module bmt_term_decode
  import bmt_pkg::*;
(
  input  logic  trdy_n,
  input  logic  devsel_n,
  input  logic  stop_n,
  output term_e term
);

  // stop has precedence; trdy with stop is a disconnect carrying data
  always_comb begin
    if (!stop_n) begin
      if (!trdy_n)        term = TM_DISC;
      else if (!devsel_n) term = TM_RETRY;
      else                term = TM_ABORT;
    end else if (!trdy_n) begin
      term = TM_XFER;
    end else begin
      term = TM_WAIT;
    end
  end

endmodule

// File: rtl/bmt_wrap_addr.sv
module bmt_wrap_addr #(
  parameter int AW         = 32,
  parameter int LINE_WORDS = 8
) (
  input  logic [AW-1:0]                 base,
  input  logic [$clog2(LINE_WORDS)-1:0] idx,
  output logic [AW-1:0]                 addr
);

  localparam int OFFW = $clog2(LINE_WORDS);

  logic [OFFW-1:0] off;

  // offset arithmetic truncates to OFFW bits, giving the wrap
  assign off  = base[OFFW+1:2] + idx;
  assign addr = {base[AW-1:OFFW+2], off, base[1:0]};

endmodule

// File: rtl/bmt_master.sv
module bmt_master
  import bmt_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DW         = 32,
  parameter int LINE_WORDS = 8,
  parameter int MA_LIMIT   = 5,
  parameter int RETRY_GAP  = 4,
  localparam int BW        = $clog2(LINE_WORDS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [BW-1:0] req_len,
  input  logic          req_refill,
  input  logic          refill_needed,
  output logic          rd_valid,
  output logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic          done_valid,
  output logic [1:0]    done_status,
  output logic [BW-1:0] done_beats,
  output logic          bus_err,
  output logic          req_n,
  input  logic          gnt_n,
  output logic          frame_n,
  output logic          irdy_n,
  output logic          ad_oe,
  output logic [AW-1:0] ad_o,
  input  logic [DW-1:0] ad_i,
  output logic [3:0]    cbe_n,
  input  logic          trdy_n,
  input  logic          devsel_n,
  input  logic          stop_n,
  input  logic          snp_frame_n,
  input  logic          snp_cbe0_n,
  output logic          snoop_done
);

  localparam int OFFW = $clog2(LINE_WORDS);
  localparam int GW   = $clog2(RETRY_GAP + 1);
  localparam int MW   = $clog2(MA_LIMIT + 1);

  bus_state_e    st;
  logic          cur_v, cur_retried, cur_refill;
  logic [AW-1:0] cur_addr;
  logic [BW-1:0] cur_len;
  logic          park_v, park_refill;
  logic [AW-1:0] park_addr;
  logic [BW-1:0] park_len;
  logic [GW-1:0] gap;
  logic [BW-1:0] beat;
  logic [MW-1:0] ma_cnt;
  logic          dev_seen;
  term_e         term;
  logic [AW-1:0] beat_addr;
  logic          last_beat, drop_now, ma_hit;

  bmt_term_decode u_dec (
    .trdy_n   (trdy_n),
    .devsel_n (devsel_n),
    .stop_n   (stop_n),
    .term     (term)
  );

  bmt_wrap_addr #(
    .AW         (AW),
    .LINE_WORDS (LINE_WORDS)
  ) u_wrap (
    .base (cur_addr),
    .idx  (beat[OFFW-1:0]),
    .addr (beat_addr)
  );

  assign last_beat = (beat == cur_len - BW'(1));
  assign drop_now  = cur_retried && cur_refill && !refill_needed;
  assign ma_hit    = devsel_n && !dev_seen && (ma_cnt == MW'(MA_LIMIT - 1));

  assign req_ready  = (st == S_IDLE) && !cur_v;
  assign req_n      = (st != S_REQ);
  assign frame_n    = !((st == S_ADDR) || ((st == S_DATA) && !last_beat));
  assign irdy_n     = (st != S_DATA);
  assign ad_oe      = (st == S_ADDR);
  assign ad_o       = ad_oe ? cur_addr : '0;
  assign cbe_n      = ad_oe ? (cur_refill ? CMD_LINE : CMD_READ) : 4'b0000;
  assign snoop_done = snp_frame_n | snp_cbe0_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cur_v       <= 1'b0;
      cur_retried <= 1'b0;
      cur_refill  <= 1'b0;
      cur_addr    <= '0;
      cur_len     <= '0;
      park_v      <= 1'b0;
      park_refill <= 1'b0;
      park_addr   <= '0;
      park_len    <= '0;
      gap         <= '0;
      beat        <= '0;
      ma_cnt      <= '0;
      dev_seen    <= 1'b0;
      rd_valid    <= 1'b0;
      rd_addr     <= '0;
      rd_data     <= '0;
      done_valid  <= 1'b0;
      done_status <= DS_OK;
      done_beats  <= '0;
      bus_err     <= 1'b0;
    end else begin
      rd_valid   <= 1'b0;
      done_valid <= 1'b0;
      bus_err    <= 1'b0;
      if (gap != '0) gap <= gap - GW'(1);
      case (st)
        S_IDLE: begin
          if (cur_v) begin
            if (!cur_retried || gap == '0) begin
              if (drop_now) begin
                cur_v       <= 1'b0;
                done_valid  <= 1'b1;
                done_status <= DS_DROP;
                done_beats  <= '0;
              end else begin
                st <= S_REQ;
              end
            end
          end else if (req_valid) begin
            // fresh demand goes ahead of a parked retry
            cur_v       <= 1'b1;
            cur_retried <= 1'b0;
            cur_addr    <= req_addr;
            cur_len     <= req_len;
            cur_refill  <= req_refill;
          end else if (park_v && gap == '0) begin
            cur_v       <= 1'b1;
            cur_retried <= 1'b1;
            cur_addr    <= park_addr;
            cur_len     <= park_len;
            cur_refill  <= park_refill;
            park_v      <= 1'b0;
          end
        end
        S_REQ: begin
          if (!gnt_n && snp_frame_n) st <= S_ADDR;
        end
        S_ADDR: begin
          st       <= S_DATA;
          beat     <= '0;
          ma_cnt   <= '0;
          dev_seen <= 1'b0;
        end
        S_DATA: begin
          if (!devsel_n)     dev_seen <= 1'b1;
          else if (!dev_seen) ma_cnt  <= ma_cnt + MW'(1);
          case (term)
            TM_ABORT: begin
              st          <= S_TURN;
              cur_v       <= 1'b0;
              done_valid  <= 1'b1;
              done_status <= DS_ERR;
              done_beats  <= beat;
              bus_err     <= 1'b1;
            end
            TM_RETRY: begin
              st  <= S_TURN;
              gap <= GW'(RETRY_GAP);
              if (!park_v) begin
                park_v      <= 1'b1;
                park_addr   <= cur_addr;
                park_len    <= cur_len;
                park_refill <= cur_refill;
                cur_v       <= 1'b0;
              end else begin
                cur_retried <= 1'b1;
              end
            end
            TM_XFER, TM_DISC: begin
              rd_valid <= 1'b1;
              rd_addr  <= beat_addr;
              rd_data  <= ad_i;
              beat     <= beat + BW'(1);
              if (last_beat || term == TM_DISC) begin
                st          <= S_TURN;
                cur_v       <= 1'b0;
                done_valid  <= 1'b1;
                done_status <= last_beat ? DS_OK : DS_DISC;
                done_beats  <= beat + BW'(1);
              end
            end
            default: begin
              if (ma_hit) begin
                st          <= S_TURN;
                cur_v       <= 1'b0;
                done_valid  <= 1'b1;
                done_status <= DS_ERR;
                done_beats  <= beat;
                bus_err     <= 1'b1;
              end
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R1: address phase only follows a sampled grant
  p_grant_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ADDR) |-> $past(!gnt_n && !req_n));

  // R2: address phase drives frame but not initiator ready
  p_addr_phase_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> (!frame_n && irdy_n));

  // R3: ready is released only with frame already high
  p_irdy_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irdy_n) |-> frame_n);

  // R4: every read beat stays in the requested line
  p_wrap_in_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_addr[AW-1:OFFW+2] == cur_addr[AW-1:OFFW+2]));

  // R6: a retry moves no data
  p_retry_no_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && term == TM_RETRY) |=> !rd_valid);

  // R9: target abort raises the bus error
  p_abort_err_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && term == TM_ABORT) |=> (bus_err && done_valid));

  // R12: a sampled stop ends the cycle cleanly
  p_stop_release_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && !stop_n) |=> (frame_n && irdy_n));

endmodule

// File: tb/bmt_master_tb_top.sv
module bmt_master_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int MA_LIMIT   = 5;
  localparam logic [31:0] KEY = 32'h5A00_00A5;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  len;
    logic        refill;
    logic        need;
    logic [3:0]  lat;
    logic [3:0]  disc;
    logic [1:0]  retries;
    logic        abort;
    logic        nodev;
    logic [1:0]  est;
    logic [3:0]  ebeats;
    logic        eerr;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_1000, 4'd1, 1'b0, 1'b1, 4'd0, 4'hF, 2'd0, 1'b0, 1'b0, 2'd0, 4'd1, 1'b0},
    '{32'h0000_1014, 4'd8, 1'b0, 1'b1, 4'd1, 4'hF, 2'd0, 1'b0, 1'b0, 2'd0, 4'd8, 1'b0},
    '{32'h0000_2008, 4'd4, 1'b0, 1'b1, 4'd2, 4'd1, 2'd0, 1'b0, 1'b0, 2'd1, 4'd2, 1'b0},
    '{32'h0000_2000, 4'd3, 1'b0, 1'b1, 4'd0, 4'd2, 2'd0, 1'b0, 1'b0, 2'd0, 4'd3, 1'b0},
    '{32'h0000_3004, 4'd4, 1'b0, 1'b1, 4'd1, 4'hF, 2'd0, 1'b1, 1'b0, 2'd2, 4'd0, 1'b1},
    '{32'h0000_4000, 4'd2, 1'b0, 1'b1, 4'd0, 4'hF, 2'd0, 1'b0, 1'b1, 2'd2, 4'd0, 1'b1},
    '{32'h0000_5018, 4'd2, 1'b0, 1'b1, 4'd0, 4'hF, 2'd1, 1'b0, 1'b0, 2'd0, 4'd2, 1'b0},
    '{32'h0000_601C, 4'd8, 1'b1, 1'b1, 4'd1, 4'hF, 2'd1, 1'b0, 1'b0, 2'd0, 4'd8, 1'b0},
    '{32'h0000_7000, 4'd8, 1'b1, 1'b0, 4'd0, 4'hF, 2'd1, 1'b0, 1'b0, 2'd3, 4'd0, 1'b0}
  };

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_refill, refill_needed;
  logic [31:0] req_addr;
  logic [3:0]  req_len;
  logic        rd_valid, done_valid, bus_err;
  logic [31:0] rd_addr, rd_data;
  logic [1:0]  done_status;
  logic [3:0]  done_beats;
  logic        req_n, gnt_n, frame_n, irdy_n, ad_oe;
  logic [31:0] ad_o, ad_i;
  logic [3:0]  cbe_n;
  logic        trdy_n, devsel_n, stop_n;
  logic        snp_frame_n, snp_cbe0_n, snoop_done;

  int n_chk = 0;
  int n_fail = 0;

  // responder configuration and observations
  logic [3:0]  cfg_lat, cfg_disc, cfg_len;
  int          retries_left;
  logic        cfg_abort, cfg_nodev, gnt_hold;
  logic        retry_fired;
  int          n_addr;
  logic [31:0] seen_addr [64];
  logic [3:0]  last_cmd;
  int          ph, xf, frm_err, stop_err;
  logic [31:0] tgt_base;
  logic        stop_drv;

  // monitor state
  logic        mon_en;
  logic [31:0] mon_base;
  int          mon_idx, done_cnt;
  logic [1:0]  last_st;
  logic [3:0]  last_beats;
  logic        last_err;

  bmt_master dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .req_refill(req_refill), .refill_needed(refill_needed),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
    .done_valid(done_valid), .done_status(done_status), .done_beats(done_beats),
    .bus_err(bus_err), .req_n(req_n), .gnt_n(gnt_n), .frame_n(frame_n),
    .irdy_n(irdy_n), .ad_oe(ad_oe), .ad_o(ad_o), .ad_i(ad_i), .cbe_n(cbe_n),
    .trdy_n(trdy_n), .devsel_n(devsel_n), .stop_n(stop_n),
    .snp_frame_n(snp_frame_n), .snp_cbe0_n(snp_cbe0_n), .snoop_done(snoop_done)
  );

  function automatic logic [31:0] wrapa(input logic [31:0] a, input int i);
    logic [2:0] o;
    o = a[4:2] + 3'(i);
    return {a[31:5], o, a[1:0]};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  // target and arbiter responder
  initial begin
    gnt_n = 1'b1; trdy_n = 1'b1; devsel_n = 1'b1; stop_n = 1'b1; ad_i = '0;
    n_addr = 0; ph = 0; xf = 0; frm_err = 0; stop_err = 0; stop_drv = 1'b0;
    retry_fired = 1'b0; tgt_base = '0; last_cmd = '0;
    forever begin
      @(negedge clk);
      if (stop_drv && !(frame_n && irdy_n)) stop_err++;
      stop_drv = 1'b0;
      gnt_n = gnt_hold ? 1'b1 : req_n;
      trdy_n = 1'b1; devsel_n = 1'b1; stop_n = 1'b1;
      if (ad_oe) begin
        if (n_addr < 64) seen_addr[n_addr] = ad_o;
        n_addr++;
        last_cmd = cbe_n;
        tgt_base = ad_o;
        ph = 0;
        xf = 0;
      end else if (!irdy_n) begin
        if (!cfg_nodev && ph >= int'(cfg_lat)) begin
          if (retries_left > 0) begin
            stop_n = 1'b0; devsel_n = 1'b0;
            retries_left--;
            retry_fired = 1'b1;
            stop_drv = 1'b1;
          end else if (cfg_abort) begin
            stop_n = 1'b0;
            stop_drv = 1'b1;
          end else begin
            devsel_n = 1'b0; trdy_n = 1'b0;
            ad_i = wrapa(tgt_base, xf) ^ KEY;
            if (frame_n != (xf == int'(cfg_len) - 1)) frm_err++;
            if (xf == int'(cfg_disc)) begin
              stop_n = 1'b0;
              stop_drv = 1'b1;
            end
            xf++;
          end
        end
        ph++;
      end
    end
  end

  // result monitor
  initial begin
    done_cnt = 0; mon_idx = 0;
    last_st = '0; last_beats = '0; last_err = 1'b0;
    forever begin
      @(negedge clk);
      if (rd_valid && mon_en) begin
        chk(rd_addr == wrapa(mon_base, mon_idx), "R4 beat address", rd_addr,
            wrapa(mon_base, mon_idx));
        chk(rd_data == (rd_addr ^ KEY), "R4 beat data", rd_data, rd_addr ^ KEY);
        mon_idx++;
      end
      if (done_valid) begin
        done_cnt++;
        last_st = done_status;
        last_beats = done_beats;
        last_err = bus_err;
      end
    end
  end

  task automatic send(input logic [31:0] a, input logic [3:0] l, input logic rf);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = l; req_refill = rf;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input int target);
    while (done_cnt < target) @(negedge clk);
  endtask

  initial begin
    int n0, d0;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0; req_refill = 1'b0;
    refill_needed = 1'b1; snp_frame_n = 1'b1; snp_cbe0_n = 1'b1;
    cfg_lat = '0; cfg_disc = 4'hF; cfg_len = 4'd1; retries_left = 0;
    cfg_abort = 1'b0; cfg_nodev = 1'b0; gnt_hold = 1'b0; mon_en = 1'b0; mon_base = '0;
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(req_n && frame_n && irdy_n, "R13 bus lines idle", {req_n, frame_n, irdy_n}, 3'b111);
    chk(req_ready, "R13 ready", req_ready, 1);
    chk(!ad_oe && !rd_valid && !done_valid && !bus_err, "R13 pulses low",
        {ad_oe, rd_valid, done_valid, bus_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 snoop-done combinations
    for (int i = 0; i < 4; i++) begin
      snp_frame_n = i[1]; snp_cbe0_n = i[0];
      #1;
      chk(snoop_done == (i[1] | i[0]), "R11 snoop done", snoop_done, i[1] | i[0]);
    end
    snp_frame_n = 1'b1; snp_cbe0_n = 1'b1;

    // vector table
    for (int v = 0; v < NV; v++) begin
      n0 = n_addr; d0 = done_cnt;
      cfg_lat = VECS[v].lat; cfg_disc = VECS[v].disc; cfg_len = VECS[v].len;
      retries_left = int'(VECS[v].retries);
      cfg_abort = VECS[v].abort; cfg_nodev = VECS[v].nodev;
      refill_needed = VECS[v].need;
      mon_en = 1'b1; mon_base = VECS[v].addr; mon_idx = 0;
      frm_err = 0; stop_err = 0;
      send(VECS[v].addr, VECS[v].len, VECS[v].refill);
      wait_done(d0 + 1);
      repeat (2) @(negedge clk);
      chk(last_st == VECS[v].est, "R5 R9 R10 status", last_st, VECS[v].est);
      chk(last_beats == VECS[v].ebeats, "R5 beats", last_beats, VECS[v].ebeats);
      chk(mon_idx == int'(VECS[v].ebeats), "R4 beat count", mon_idx, VECS[v].ebeats);
      chk(last_err == VECS[v].eerr, "R9 bus_err", last_err, VECS[v].eerr);
      chk(seen_addr[n0] == VECS[v].addr, "R2 address", seen_addr[n0], VECS[v].addr);
      chk(last_cmd == (VECS[v].refill ? 4'hE : 4'h6), "R2 command", last_cmd,
          VECS[v].refill ? 4'hE : 4'h6);
      chk(n_addr - n0 == int'(VECS[v].retries) + (VECS[v].est == 2'd3 ? 0 : 1),
          "R6 R8 address phases", n_addr - n0,
          int'(VECS[v].retries) + (VECS[v].est == 2'd3 ? 0 : 1));
      chk(frm_err == 0, "R3 frame timing", frm_err, 0);
      chk(stop_err == 0, "R12 release after stop", stop_err, 0);
      if (VECS[v].nodev) chk(ph == MA_LIMIT, "R10 timeout length", ph, MA_LIMIT);
    end

    // R1 grant withheld: request stays pending, no address phase
    mon_en = 1'b0; cfg_lat = '0; cfg_disc = 4'hF; cfg_len = 4'd1;
    cfg_abort = 1'b0; cfg_nodev = 1'b0; retries_left = 0; refill_needed = 1'b1;
    gnt_hold = 1'b1; d0 = done_cnt; n0 = n_addr;
    send(32'h0000_A000, 4'd1, 1'b0);
    repeat (4) @(negedge clk);
    chk(!req_n && frame_n, "R1 waits for grant", {req_n, frame_n}, 2'b01);
    chk(n_addr == n0, "R1 no address phase", n_addr, n0);
    gnt_hold = 1'b0;
    wait_done(d0 + 1);
    chk(last_st == 2'd0, "R1 completes after grant", last_st, 0);

    // R7 new request overtakes a parked retry
    repeat (2) @(negedge clk);
    d0 = done_cnt; n0 = n_addr; retry_fired = 1'b0; retries_left = 1;
    send(32'h0000_8000, 4'd1, 1'b0);
    while (!retry_fired) @(negedge clk);
    send(32'h0000_9000, 4'd1, 1'b0);
    wait_done(d0 + 2);
    repeat (2) @(negedge clk);
    chk(n_addr == n0 + 3, "R7 address phases", n_addr, n0 + 3);
    chk(seen_addr[n0 + 1] == 32'h0000_9000, "R7 new request first", seen_addr[n0 + 1],
        32'h0000_9000);
    chk(seen_addr[n0 + 2] == 32'h0000_8000, "R6 retried reissued", seen_addr[n0 + 2],
        32'h0000_8000);
    chk(last_st == 2'd0, "R6 retried completes", last_st, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule